// File: doc/BRIEF.md
# External Bus Cycle Controller with Wait Extension

This block turns single-beat read and write requests from a processor core into cycles on an external bus with 8-bit data and 16-bit address. While a cycle is active it holds the address, the direction line and a valid-cycle qualifier steady. On writes it drives the data a short, fixed time after the address, so the addressed device has settled before data arrives. A nominal cycle lasts a fixed number of fast clocks. When it ends, the controller captures the read data and returns a one-clock completion pulse to the requester.

A slow device holds the ready input low to ask for more time. Ready is sampled once per bus period, at the clock where the cycle would otherwise close. Each low sample adds one whole period. The number of added periods is capped by a parameter derived from the clock frequency so that a cycle never exceeds 10 us. At the cap the cycle is closed anyway, the captured data is replaced by all ones and a timeout pulse is raised.

A small decoder gates the top address bits with the valid qualifier to produce one select line per address region.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: After reset and whenever no cycle is active, `bus_vma_o` is 0, `bus_doe_o` is 0, every bit of `sel_o` is 0 and `req_ready_o` is 1.
- R2: A request seen with `req_i`=1 while `req_ready_o`=1 starts a cycle on the next clock. From then until the cycle ends, `bus_vma_o` is 1, `bus_addr_o` equals the requested address and `bus_rw_o` is 1 for a read (`req_we_i`=0) or 0 for a write (`req_we_i`=1), all held stable.
- R3: In a write cycle, `bus_doe_o` rises WDATA_DLY (default 1) clocks after `bus_vma_o` rises and stays high until the cycle ends, with `bus_dout_o` equal to the request data. In a read cycle `bus_doe_o` stays 0.
- R4: With `mem_rdy_i` high, `bus_vma_o` stays high for exactly PHASE_CLKS (default 4) clocks. `done_o` is 1 in the clock right after `bus_vma_o` falls.
- R5: Each time `mem_rdy_i` is sampled low at the end point of a period, and the limit has not been reached, the cycle lasts exactly PHASE_CLKS more clocks. Ready is not looked at in any other clock.
- R6: In a read that ends normally, `rdata_o` shows the `bus_din_i` value present at the final clock edge. It is valid from the clock where `done_o` is 1.
- R7: After WAIT_LIMIT extensions, a low ready sample ends the cycle. WAIT_LIMIT is computed so that (WAIT_LIMIT+1)*PHASE_CLKS clocks equal 10 us; the default is 124, giving 500 clocks at 50 MHz. `timeout_o` and `done_o` are then 1 together and `rdata_o` is 0xFF, for reads and writes alike.
- R8: `sel_o[i]` is 1 exactly when `bus_vma_o` is 1 and `bus_addr_o[15:14]` equals i. At most one select is active at a time.
- R9: While a cycle is active `req_ready_o` is 0, and `req_i` has no effect on the bus signals.
- R10: `done_o` and `timeout_o` are single-clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe from the core |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Request write data |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| done_o | output | 1 | One-clock completion pulse |
| timeout_o | output | 1 | One-clock pulse when the extension limit forced the end |
| rdata_o | output | 8 | Captured read data (0xFF after a timeout) |
| bus_addr_o | output | 16 | Bus address |
| bus_rw_o | output | 1 | Direction: 1 read, 0 write |
| bus_vma_o | output | 1 | Valid-cycle qualifier |
| bus_dout_o | output | 8 | Write data toward the bus (0 when not driven) |
| bus_doe_o | output | 1 | Write data drive enable |
| bus_din_i | input | 8 | Read data from the bus |
| mem_rdy_i | input | 1 | Device ready; low asks for another period |
| sel_o | output | 4 | Region selects, one per value of the top two address bits |

## Verification
The assertions assume that `mem_rdy_i` and `bus_din_i` are synchronous to `clk` and settled before each rising edge. They also assume the core only counts on a request being taken when `req_ready_o` is high. The stimulus changes every input at the falling edge and returns read data combinationally from the bus address, so both hold. It lowers ready at the request and raises it only after the chosen number of end-point samples has passed. It pokes `req_i` in the middle of busy cycles to show that such pokes are ignored rather than breaking the cycle.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } xbc_state_e;

  // Extra periods allowed so that (limit+1) periods fill the time ceiling.
  function automatic int unsigned wait_limit_f(input int unsigned clk_hz,
                                               input int unsigned per_clks,
                                               input int unsigned max_ns);
    int unsigned total_clks;
    total_clks = (clk_hz / 1000) * max_ns / 1_000_000;
    if (total_clks < 2 * per_clks) return 0;
    return total_clks / per_clks - 1;
  endfunction

  // Value held in the read-data register after a cycle ends.
  function automatic logic [7:0] capture_f(input logic forced,
                                           input logic is_read,
                                           input logic [7:0] din,
                                           input logic [7:0] old);
    if (forced) return 8'hFF;
    if (is_read) return din;
    return old;
  endfunction

endpackage

// File: rtl/xbc_wait_timer.sv
module xbc_wait_timer #(
  parameter int unsigned PHASE_CLKS = 4,
  parameter int unsigned WAIT_LIMIT = 124,
  parameter int unsigned PH_W       = 2,
  parameter int unsigned WAIT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              ext_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [WAIT_W-1:0] waits_o,
  output logic              end_pt_o,
  output logic              at_limit_o
);

  logic [PH_W-1:0]   phase_q;
  logic [WAIT_W-1:0] waits_q;

  assign end_pt_o   = (phase_q == PH_W'(PHASE_CLKS - 1));
  assign at_limit_o = (waits_q == WAIT_W'(WAIT_LIMIT));
  assign phase_o    = phase_q;
  assign waits_o    = waits_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      phase_q <= '0;
      waits_q <= '0;
    end else if (run_i) begin
      if (end_pt_o) begin
        phase_q <= '0;
        if (ext_i) waits_q <= waits_q + WAIT_W'(1);
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/xbc_sel_decode.sv
module xbc_sel_decode #(
  parameter int unsigned CS_BITS = 2,
  parameter int unsigned NUM_CS  = 4
) (
  input  logic               vma_i,
  input  logic [CS_BITS-1:0] addr_hi_i,
  output logic [NUM_CS-1:0]  sel_o
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    assign sel_o[i] = vma_i && (addr_hi_i == CS_BITS'(i));
  end

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned PHASE_CLKS = 4,
  parameter int unsigned WDATA_DLY  = 1,
  parameter int unsigned MAX_NS     = 10_000,
  parameter int unsigned CS_BITS    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_i,
  input  logic                      req_we_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      req_ready_o,
  output logic                      done_o,
  output logic                      timeout_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [ADDR_W-1:0]         bus_addr_o,
  output logic                      bus_rw_o,
  output logic                      bus_vma_o,
  output logic [DATA_W-1:0]         bus_dout_o,
  output logic                      bus_doe_o,
  input  logic [DATA_W-1:0]         bus_din_i,
  input  logic                      mem_rdy_i,
  output logic [(1<<CS_BITS)-1:0]   sel_o
);
  import xbc_pkg::*;

  localparam int unsigned NUM_CS     = 1 << CS_BITS;
  localparam int unsigned WAIT_LIMIT = wait_limit_f(CLK_HZ, PHASE_CLKS, MAX_NS);
  localparam int unsigned PH_W       = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
  localparam int unsigned WAIT_W     = $clog2(WAIT_LIMIT + 2);

  xbc_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              to_q;

  logic [PH_W-1:0]   phase;
  logic [WAIT_W-1:0] waits;
  logic              end_pt;
  logic              at_limit;

  // Named cycle events, shared by the control logic and the checker.
  logic busy;
  logic cyc_start;
  logic cyc_sample;
  logic cyc_extend;
  logic cyc_end_ok;
  logic cyc_end_to;
  logic cyc_end;

  assign busy       = (state_q == ST_BUSY);
  assign cyc_start  = !busy && req_i;
  assign cyc_sample = busy && end_pt;
  assign cyc_extend = cyc_sample && !mem_rdy_i && !at_limit;
  assign cyc_end_ok = cyc_sample && mem_rdy_i;
  assign cyc_end_to = cyc_sample && !mem_rdy_i && at_limit;
  assign cyc_end    = cyc_end_ok || cyc_end_to;

  xbc_wait_timer #(
    .PHASE_CLKS (PHASE_CLKS),
    .WAIT_LIMIT (WAIT_LIMIT),
    .PH_W       (PH_W),
    .WAIT_W     (WAIT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cyc_start),
    .run_i      (busy),
    .ext_i      (cyc_extend),
    .phase_o    (phase),
    .waits_o    (waits),
    .end_pt_o   (end_pt),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= cyc_end;
      to_q   <= cyc_end_to;
      if (cyc_start) begin
        state_q <= ST_BUSY;
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end else if (cyc_end) begin
        state_q <= ST_IDLE;
        rdata_q <= capture_f(cyc_end_to, !we_q, bus_din_i, rdata_q);
      end
    end
  end

  assign bus_doe_o   = busy && we_q &&
                       ((phase >= PH_W'(WDATA_DLY)) || (waits != '0));
  assign bus_dout_o  = bus_doe_o ? wdata_q : '0;
  assign bus_vma_o   = busy;
  assign bus_addr_o  = addr_q;
  assign bus_rw_o    = busy ? !we_q : 1'b1;
  assign req_ready_o = !busy;
  assign done_o      = done_q;
  assign timeout_o   = to_q;
  assign rdata_o     = rdata_q;

  xbc_sel_decode #(
    .CS_BITS   (CS_BITS),
    .NUM_CS    (NUM_CS)
  ) u_sel (
    .vma_i     (busy),
    .addr_hi_i (addr_q[ADDR_W-1 -: CS_BITS]),
    .sel_o     (sel_o)
  );

endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic              bus_vma_o,
  input logic              bus_rw_o,
  input logic              bus_doe_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [NUM_CS-1:0] sel_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cyc_start,
  input logic              cyc_extend,
  input logic              cyc_end_to
);

  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vma_o |-> (sel_o == '0) && !bus_doe_o);

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  // R2
  start_vma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> bus_vma_o);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vma_o && $past(bus_vma_o) |-> $stable(bus_addr_o) && $stable(bus_rw_o));

  // R3
  doe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe_o |-> bus_vma_o && !bus_rw_o);

  // R4
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_vma_o) |-> done_o);

  // R5
  extend_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_extend |=> bus_vma_o && !done_o);

  // R7
  timeout_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end_to |=> timeout_o && done_o && (rdata_o == '1));

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vma_o |-> !req_ready_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

endmodule

bind xbus_cycle_ctrl xbc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_CS (1 << CS_BITS)
) u_xbc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready_o (req_ready_o),
  .bus_vma_o   (bus_vma_o),
  .bus_rw_o    (bus_rw_o),
  .bus_doe_o   (bus_doe_o),
  .bus_addr_o  (bus_addr_o),
  .sel_o       (sel_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .rdata_o     (rdata_o),
  .cyc_start   (cyc_start),
  .cyc_extend  (cyc_extend),
  .cyc_end_to  (cyc_end_to)
);

// File: tb/test_xbus_cycle_ctrl.sv
`timescale 1ns/1ps
module test_xbus_cycle_ctrl;

  localparam int PH    = 4;
  localparam int WDLY  = 1;
  localparam int LIMIT = (10_000 / 20) / PH - 1;  // 10 us at 20 ns per clock

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        req_ready_o, done_o, timeout_o;
  logic [7:0]  rdata_o;
  logic [15:0] bus_addr_o;
  logic        bus_rw_o, bus_vma_o, bus_doe_o;
  logic [7:0]  bus_dout_o;
  logic [7:0]  bus_din_i;
  logic        mem_rdy_i = 1'b1;
  logic [3:0]  sel_o;

  int tot = 0;
  int bad = 0;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign bus_din_i = mem_val(bus_addr_o);

  always #10 clk = ~clk;

  xbus_cycle_ctrl i_xbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o), .done_o(done_o), .timeout_o(timeout_o),
    .rdata_o(rdata_o), .bus_addr_o(bus_addr_o), .bus_rw_o(bus_rw_o),
    .bus_vma_o(bus_vma_o), .bus_dout_o(bus_dout_o), .bus_doe_o(bus_doe_o),
    .bus_din_i(bus_din_i), .mem_rdy_i(mem_rdy_i), .sel_o(sel_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input bit we, input logic [15:0] a, input logic [7:0] d,
                         input int n, input bit poke);
    int   cnt;
    int   exp_cnt;
    bit   exp_to;
    logic [7:0] exp_rd;
    cnt     = 0;
    exp_to  = (n > LIMIT);
    exp_cnt = PH * ((exp_to ? LIMIT : n) + 1);
    @(negedge clk);
    chk("R9 ready when idle", 32'(req_ready_o), 32'd1);
    req_i       = 1'b1;
    req_we_i    = we;
    req_addr_i  = a;
    req_wdata_i = d;
    mem_rdy_i   = (n == 0);
    @(negedge clk);
    req_i = 1'b0;
    while (!done_o && cnt < 2000) begin
      if (bus_vma_o) cnt++;
      if (cnt == 1) begin
        chk("R2 address", 32'(bus_addr_o), 32'(a));
        chk("R2 direction", 32'(bus_rw_o), 32'(!we));
        chk("R8 select", 32'(sel_o), 32'(4'b0001 << a[15:14]));
      end
      chk("R3 drive enable", 32'(bus_doe_o), 32'(we && cnt >= 1 + WDLY));
      if (bus_doe_o) chk("R3 write data", 32'(bus_dout_o), 32'(d));
      if (poke && cnt == 2) begin
        req_i = 1'b1; req_addr_i = ~a; req_we_i = ~we;
      end
      if (poke && cnt == 3) begin
        req_i = 1'b0;
        chk("R9 address kept during poke", 32'(bus_addr_o), 32'(a));
        chk("R9 ready low while busy", 32'(req_ready_o), 32'd0);
      end
      if (n > 0 && cnt == PH * n + 1) mem_rdy_i = 1'b1;
      @(negedge clk);
    end
    chk("R4/R5 cycle length", 32'(cnt), 32'(exp_cnt));
    chk("R4 qualifier low at done", 32'(bus_vma_o), 32'd0);
    chk("R7 timeout flag", 32'(timeout_o), 32'(exp_to));
    if (exp_to) begin
      chk("R7 forced data", 32'(rdata_o), 32'hFF);
    end else if (!we) begin
      exp_rd = mem_val(a);
      chk("R6 read data", 32'(rdata_o), 32'(exp_rd));
    end
    mem_rdy_i = 1'b1;
    @(negedge clk);
    chk("R10 done pulse", 32'(done_o), 32'd0);
    chk("R10 timeout pulse", 32'(timeout_o), 32'd0);
    chk("R1 idle qualifier", 32'(bus_vma_o), 32'd0);
    chk("R1 idle selects", 32'(sel_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tot++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset qualifier", 32'(bus_vma_o), 32'd0);
    chk("R1 reset drive enable", 32'(bus_doe_o), 32'd0);
    chk("R1 reset selects", 32'(sel_o), 32'd0);
    chk("R1 reset ready", 32'(req_ready_o), 32'd1);
    chk("R10 reset done", 32'(done_o), 32'd0);

    run_txn(1'b0, 16'h1234, 8'h00, 0, 1'b0);
    run_txn(1'b1, 16'h4321, 8'hA5, 0, 1'b0);
    run_txn(1'b0, 16'h8001, 8'h00, 3, 1'b0);
    run_txn(1'b1, 16'hC0DE, 8'h3C, 2, 1'b1);
    run_txn(1'b0, 16'hFFFF, 8'h00, 1, 1'b1);
    run_txn(1'b0, 16'h7E55, 8'h00, LIMIT, 1'b0);
    run_txn(1'b0, 16'hBEEF, 8'h00, LIMIT + 1, 1'b0);
    run_txn(1'b1, 16'h0F0F, 8'h99, LIMIT + 7, 1'b0);

    for (int k = 0; k < 60; k++) begin
      bit          rw;
      logic [15:0] ad;
      logic [7:0]  dt;
      int          nw;
      bit          pk;
      rw = 1'($urandom % 2);
      ad = 16'($urandom);
      dt = 8'($urandom);
      nw = ($urandom % 3 == 0) ? int'($urandom % 6) : 0;
      pk = ($urandom % 4 == 0);
      run_txn(rw, ad, dt, nw, pk);
    end

    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule